// File: doc/BRIEF.md
# Flash Row Fast-Program Sequencer

This block stages one full row of 64-bit words for an embedded flash array and then commits that row in a single burst. Software writes the row through a bus port at flash addresses. A tracker checks that the writes are in order while they arrive. Software then sets a start bit, and the block either commits the row word by word over a ready-handshaked array port, or refuses it and raises an error flag.

A small control register selects the mode and holds the interrupt enables. A status register reports busy, completion, a sequence error and a write-protection error. A per-page protection mask arrives as an input. Two level interrupt outputs follow the flags gated by their enables. After a row completes, software may load and start the next row without leaving fast mode.

Top module: `flash_row_pgm`

## Requirements
- R1: Fast mode is on only when ctrl bits [1:0] equal 2'b01 and ctrl bit 2 (fast enable) is 1. Outside fast mode, bus writes and start requests are ignored, and any partially loaded row is discarded.
- R2: A bus write is accepted only when bus_addr[31:24] equals 8'h08. Writes to other addresses are ignored and do not disturb the row being loaded.
- R3: The first accepted word must be aligned to the row size (WORDS×8 bytes), and each later word must be at the previous address plus 8. At start, a row that breaks this order, or that holds fewer or more than WORDS words, sets status bit 2 (sequence error) and writes nothing to the array.
- R4: A start (a ctrl write with bit 3 set) on a valid row sets status bit 0 (busy) from the next cycle. The block writes word i, holding its buffered data, to row base + 8·i. arr_req, arr_addr and arr_data stay steady until arr_rdy is 1. Busy clears after the last word is accepted.
- R5: When the last word is accepted, status bit 1 (done) is set. irq_end is 1 while done and ctrl bit 4 are both 1.
- R6: The page index is the row base address shifted right by log2(PAGE_BYTES), kept to log2(NUM_PAGES) bits. If prot_mask has that bit set, start sets status bit 3 (protection error) and writes nothing. A sequence error takes precedence over a protection error.
- R7: irq_err is 1 while (status bit 2 or status bit 3) and ctrl bit 5 are all 1.
- R8: Status bits 1..3 clear when the bit is written as 1 with csr_sel=1. Writing 0 leaves the bit unchanged.
- R9: While busy is 1, bus writes and further start requests are ignored.
- R10: Rows may be loaded and committed back to back while the block stays in fast mode.
- R11: After reset, ctrl_q, stat_q, irq_end, irq_err and arr_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Row word write strobe |
| bus_addr | input | 32 | Absolute byte address of the word |
| bus_wdata | input | 64 | Word data |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects ctrl, 1 selects status |
| csr_wdata | input | 6 | Register write data |
| prot_mask | input | NUM_PAGES | Per-page protection, 1 = protected |
| arr_rdy | input | 1 | Array accepts the presented word |
| arr_req | output | 1 | Array word write request |
| arr_addr | output | 32 | Array word byte address |
| arr_data | output | 64 | Array word data |
| ctrl_q | output | 6 | Ctrl readback; bit 3 reads 0 |
| stat_q | output | 4 | {prot err, seq err, done, busy} |
| irq_end | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench builds the block with WORDS=4, PAGE_BYTES=64 and NUM_PAGES=8. With these values a row is 32 bytes and two rows share a page, so short, overlong, gapped and misaligned rows, as well as protected and neighbouring pages, are each only a few writes away. The array model accepts one beat in three. This keeps busy high long enough to place ignored writes and starts inside a commit.

// File: rtl/flash_row_pkg.sv
package flash_row_pkg;
  localparam logic [7:0] FLASH_HI = 8'h08;
  localparam logic [1:0] CMD_FAST = 2'b01;

  function automatic logic in_window(input logic [31:0] a);
    return a[31:24] == FLASH_HI;
  endfunction

  function automatic logic row_aligned(input logic [31:0] a, input int unsigned lsb);
    return (a & ((32'd1 << lsb) - 32'd1)) == 32'd0;
  endfunction

  function automatic logic [31:0] next_word(input logic [31:0] a);
    return a + 32'd8;
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + (idx << 3);
  endfunction

  function automatic logic [31:0] page_of(input logic [31:0] a, input int unsigned lsb,
                                          input int unsigned nbits);
    return (a >> lsb) & ((32'd1 << nbits) - 32'd1);
  endfunction
endpackage

// File: rtl/frp_seq_track.sv
module frp_seq_track import flash_row_pkg::*; #(
  parameter int unsigned WORDS = 32,
  localparam int unsigned CNT_W = $clog2(WORDS + 1),
  localparam int unsigned ROW_LSB = $clog2(WORDS * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [31:0]      addr,
  output logic [CNT_W-1:0] cnt,
  output logic             row_full,
  output logic             seq_ok,
  output logic [31:0]      base
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS);
  logic [31:0] prev_q;

  assign row_full = (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; seq_ok <= 1'b1; base <= '0; prev_q <= '0;
    end else if (clear) begin
      cnt <= '0; seq_ok <= 1'b1;
    end else if (take) begin
      prev_q <= addr;
      if (cnt == '0) begin
        cnt    <= CNT_W'(1);
        base   <= addr;
        seq_ok <= row_aligned(addr, ROW_LSB);
      end else begin
        if (row_full) seq_ok <= 1'b0;
        else          cnt    <= cnt + CNT_W'(1);
        if (addr != next_word(prev_q)) seq_ok <= 1'b0;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0); // R1
endmodule

// File: rtl/frp_row_buf.sv
module frp_row_buf #(
  parameter int unsigned WORDS = 32,
  parameter int unsigned DW    = 64,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/frp_commit.sv
module frp_commit import flash_row_pkg::*; #(
  parameter int unsigned WORDS = 32,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [31:0]      launch_base,
  input  logic             arr_rdy,
  output logic             busy,
  output logic             arr_req,
  output logic [31:0]      arr_addr,
  output logic [IDX_W-1:0] rd_idx,
  output logic             last_beat
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      base_q;

  assign arr_req   = busy;
  assign rd_idx    = idx_q;
  assign arr_addr  = word_addr(base_q, 32'(idx_q));
  assign last_beat = busy && arr_rdy && (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; idx_q <= '0; base_q <= '0;
    end else if (launch && !busy) begin
      busy <= 1'b1; idx_q <= '0; base_q <= launch_base;
    end else if (busy && arr_rdy) begin
      if (idx_q == LAST) busy  <= 1'b0;
      else               idx_q <= idx_q + IDX_W'(1);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_rdy |=> arr_req && $stable(arr_addr)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_rdy && !last_beat |=> arr_addr == $past(arr_addr) + 32'd8); // R4
  AST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> in_window(arr_addr)); // R2
endmodule

// File: rtl/flash_row_pgm.sv
module flash_row_pgm import flash_row_pkg::*; #(
  parameter int unsigned WORDS      = 32,
  parameter int unsigned DW         = 64,
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned NUM_PAGES  = 64,
  localparam int unsigned IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned CNT_W  = $clog2(WORDS + 1),
  localparam int unsigned PG_LSB = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W   = $clog2(NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 csr_wr,
  input  logic                 csr_sel,
  input  logic [5:0]           csr_wdata,
  input  logic [NUM_PAGES-1:0] prot_mask,
  input  logic                 arr_rdy,
  output logic                 arr_req,
  output logic [31:0]          arr_addr,
  output logic [DW-1:0]        arr_data,
  output logic [5:0]           ctrl_q,
  output logic [3:0]           stat_q,
  output logic                 irq_end,
  output logic                 irq_err
);
  logic [1:0] cmd_q;
  logic       fen_q, eie_q, rie_q;
  logic       done_f, seq_f, wp_f;

  logic             busy, last_beat, mode_on, bus_take, start_req, chk_start;
  logic             row_bad, prot_hit, launch, seq_set, wp_set;
  logic [CNT_W-1:0] trk_cnt;
  logic             row_full, seq_ok;
  logic [31:0]      row_base;
  logic [IDX_W-1:0] rd_idx;
  logic [PG_W-1:0]  page_idx;

  assign mode_on   = (cmd_q == CMD_FAST) && fen_q;
  assign bus_take  = bus_wr && mode_on && !busy && in_window(bus_addr);
  assign start_req = csr_wr && !csr_sel && csr_wdata[3];
  assign chk_start = start_req && mode_on && !busy;
  assign page_idx  = PG_W'(page_of(row_base, PG_LSB, PG_W));
  assign row_bad   = !(seq_ok && row_full);
  assign prot_hit  = prot_mask[page_idx];
  assign seq_set   = chk_start && row_bad;
  assign wp_set    = chk_start && !row_bad && prot_hit;
  assign launch    = chk_start && !row_bad && !prot_hit;

  frp_seq_track #(.WORDS(WORDS)) trk_i (
    .clk(clk), .rst_n(rst_n), .clear(chk_start || !mode_on), .take(bus_take),
    .addr(bus_addr), .cnt(trk_cnt), .row_full(row_full), .seq_ok(seq_ok),
    .base(row_base));

  frp_row_buf #(.WORDS(WORDS), .DW(DW)) buf_i (
    .clk(clk), .wr_en(bus_take && !row_full), .wr_idx(trk_cnt[IDX_W-1:0]),
    .wr_data(bus_wdata), .rd_idx(rd_idx), .rd_data(arr_data));

  frp_commit #(.WORDS(WORDS)) cmt_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_base(row_base),
    .arr_rdy(arr_rdy), .busy(busy), .arr_req(arr_req), .arr_addr(arr_addr),
    .rd_idx(rd_idx), .last_beat(last_beat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; fen_q <= 1'b0; eie_q <= 1'b0; rie_q <= 1'b0;
    end else if (csr_wr && !csr_sel) begin
      cmd_q <= csr_wdata[1:0]; fen_q <= csr_wdata[2];
      eie_q <= csr_wdata[4];   rie_q <= csr_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0; seq_f <= 1'b0; wp_f <= 1'b0;
    end else begin
      if (last_beat)                             done_f <= 1'b1;
      else if (csr_wr && csr_sel && csr_wdata[1]) done_f <= 1'b0;
      if (seq_set)                               seq_f  <= 1'b1;
      else if (csr_wr && csr_sel && csr_wdata[2]) seq_f  <= 1'b0;
      if (wp_set)                                wp_f   <= 1'b1;
      else if (csr_wr && csr_sel && csr_wdata[3]) wp_f   <= 1'b0;
    end
  end

  assign ctrl_q  = {rie_q, eie_q, 1'b0, fen_q, cmd_q};
  assign stat_q  = {wp_f, seq_f, done_f, busy};
  assign irq_end = done_f && eie_q;
  assign irq_err = (seq_f || wp_f) && rie_q;

  AST_NO_WRITE_AFTER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_set || wp_set) |=> !arr_req); // R3
  AST_SEQ_BEFORE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_set && wp_set)); // R6
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> done_f && !busy); // R5
  AST_BUSY_HOLDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode_on |=> trk_cnt == $past(trk_cnt)); // R9
endmodule

// File: tb/flash_row_pgm_tb.sv
module flash_row_pgm_tb_top;
  localparam int unsigned WORDS = 4;
  localparam logic [5:0] MODE  = 6'h05;
  localparam logic [5:0] START = 6'h08;
  localparam logic [5:0] EIE   = 6'h10;
  localparam logic [5:0] RIE   = 6'h20;
  localparam int NV = 9;
  localparam logic [31:0] V_BASE [NV] = '{32'h0800_0000, 32'h0800_0040, 32'h0800_0008,
    32'h0800_0040, 32'h0800_0080, 32'h0800_0080, 32'h0800_0040, 32'h0800_00C0, 32'h0800_0100};
  localparam int V_KIND [NV] = '{0, 1, 0, 3, 0, 1, 6, 0, 8};
  localparam logic [7:0] V_PROT [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h04, 8'h00, 8'h01, 8'h00};
  localparam logic [3:0] V_STAT [NV] = '{4'h2, 4'h4, 4'h4, 4'h4, 4'h8, 4'h4, 4'h4, 4'h2, 4'h2};
  localparam logic [3:0] V_REQ  [NV] = '{4'd4, 4'd3, 4'd3, 4'd3, 4'd6, 4'd6, 4'd3, 4'd6, 4'd2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, csr_wr = 1'b0, csr_sel = 1'b0, arr_rdy;
  logic [31:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [5:0]  csr_wdata = '0;
  logic [7:0]  prot_mask = '0;
  logic arr_req, irq_end, irq_err;
  logic [31:0] arr_addr;
  logic [63:0] arr_data;
  logic [5:0]  ctrl_q;
  logic [3:0]  stat_q;

  int errors = 0, checks = 0, nwr = 0, rdy_cnt = 0, cyc = 0;
  logic [63:0] mem [128];

  always #4 clk = ~clk;

  flash_row_pgm #(.WORDS(WORDS), .DW(64), .PAGE_BYTES(64), .NUM_PAGES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .prot_mask(prot_mask),
    .arr_rdy(arr_rdy), .arr_req(arr_req), .arr_addr(arr_addr), .arr_data(arr_data),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .irq_end(irq_end), .irq_err(irq_err));

  assign arr_rdy = (rdy_cnt == 0);
  always @(negedge clk) rdy_cnt <= (rdy_cnt == 2) ? 0 : rdy_cnt + 1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_req && arr_rdy) begin
      mem[arr_addr[9:3]] <= arr_data;
      nwr <= nwr + 1;
    end
  end

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {32'hC0DE_0000 ^ a, a};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr(input logic sel, input logic [5:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic bwr(input logic [31:0] a);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = pat(a);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  // kinds: 0 in order, 1 gap, 3 short, 6 one extra, 8 foreign write inside the row
  task automatic load_row(input logic [31:0] b, input int kind);
    int n;
    n = (kind == 3) ? WORDS - 1 : (kind == 6) ? WORDS + 1 : WORDS;
    for (int i = 0; i < n; i++) begin
      bwr(b + 32'(8 * ((kind == 1 && i >= 2) ? i + 1 : i)));
      if (kind == 8 && i == 1) bwr(32'h0900_0000);
    end
  endtask

  task automatic run(input logic [5:0] ie);
    csr(1'b0, MODE | START | ie);
    for (int k = 0; k < 200 && stat_q[0]; k++) @(negedge clk);
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 ctrl", 64'(ctrl_q), 64'h0);
    chk("R11 stat", 64'(stat_q), 64'h0);
    chk("R11 irq/req", 64'({irq_end, irq_err, arr_req}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // stimulus table
    for (int v = 0; v < NV; v++) begin
      csr(1'b1, 6'h0E);
      csr(1'b0, MODE);
      prot_mask = V_PROT[v];
      nwr = 0;
      load_row(V_BASE[v], V_KIND[v]);
      run(6'h00);
      chk($sformatf("R%0d stat v%0d", V_REQ[v], v), 64'(stat_q), 64'(V_STAT[v]));
      chk($sformatf("R%0d writes v%0d", V_REQ[v], v), 64'(nwr), (V_STAT[v] == 4'h2) ? 64'(WORDS) : 64'h0);
      chk("R5 R7 irq masked", 64'({irq_end, irq_err}), 64'h0);
      if (V_STAT[v] == 4'h2)
        for (int i = 0; i < WORDS; i++) begin
          logic [31:0] a;
          a = V_BASE[v] + 32'(8 * i);
          chk("R4 data", mem[a[9:3]], pat(a));
        end
    end
    prot_mask = '0;

    // R1: start outside fast mode is ignored; leaving mode drops a partial row
    csr(1'b1, 6'h0E);
    csr(1'b0, 6'h04);
    load_row(32'h0800_0180, 0);
    csr(1'b0, 6'h0C);
    chk("R1 start outside mode", 64'(stat_q), 64'h0);
    csr(1'b0, MODE);
    nwr = 0;
    run(6'h00);
    chk("R1 row written outside mode dropped", 64'(stat_q), 64'h4);
    csr(1'b1, 6'h0E);
    bwr(32'h0800_0180); bwr(32'h0800_0188);
    csr(1'b0, 6'h00);
    csr(1'b0, MODE);
    bwr(32'h0800_0190); bwr(32'h0800_0198);
    run(6'h00);
    chk("R1 partial row dropped", 64'(stat_q), 64'h4);
    chk("R1 no writes", 64'(nwr), 64'h0);

    // R7 error interrupt, R8 clear
    run(RIE);
    chk("R7 irq_err", 64'(irq_err), 64'h1);
    csr(1'b1, 6'h02);
    chk("R8 write 1 to other bit keeps seq err", 64'(stat_q), 64'h4);
    csr(1'b1, 6'h04);
    chk("R8 seq err cleared", 64'(stat_q), 64'h0);
    chk("R7 irq_err drops", 64'(irq_err), 64'h0);

    // R4 busy, R9 writes and start ignored while busy, R5 irq_end
    load_row(32'h0800_0180, 0);
    nwr = 0;
    csr(1'b0, MODE | START | EIE);
    chk("R4 busy after start", 64'(stat_q[0]), 64'h1);
    load_row(32'h0800_01A0, 0);
    csr(1'b0, MODE | START | EIE);
    for (int k = 0; k < 200 && stat_q[0]; k++) @(negedge clk);
    chk("R9 single row committed", 64'(nwr), 64'(WORDS));
    chk("R5 done", 64'(stat_q), 64'h2);
    chk("R5 irq_end", 64'(irq_end), 64'h1);
    chk("R9 busy-time row absent", mem[7'h34], 64'h0);
    csr(1'b1, 6'h02);
    chk("R8 done cleared", 64'({stat_q, irq_end}), 64'h0);
    run(6'h00);
    chk("R9 busy-time writes not kept", 64'(stat_q), 64'h4);

    // R10 back to back rows
    csr(1'b1, 6'h0E);
    load_row(32'h0800_01C0, 0); run(6'h00);
    load_row(32'h0800_01E0, 0); run(6'h00);
    chk("R10 stat", 64'(stat_q), 64'h2);
    chk("R10 row a", mem[7'h38], pat(32'h0800_01C0));
    chk("R10 row b", mem[7'h3F], pat(32'h0800_01F8));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule